// File: doc/BRIEF.md
# Clock Source Select Controller

This block decides which clock source drives the system and what happens to the clock tree, the oscillator and two timers when the chip enters a low-power mode. Software reaches it through an 8-bit control register. That register selects the PLL as the source, keeps the oscillator running through stop mode, and chooses whether the PLL, the periodic timer and the watchdog halt during wait.

The block receives the PLL lock flag, the oscillator configuration status, a special-mode flag and three level mode requests: wait, stop and self-clock. It drives the chosen source as a select output and produces a divide-by-two bus clock enable. It also drives a PLL power-down request, an oscillator enable, and hold/clear levels for the periodic timer dividers and the watchdog counter.

A mode entry is the first cycle in which a mode request is seen high. Every output is a register, and reset is synchronous and active high.

Top module: `clk_sel_ctrl`

## Requirements
- R1: After reset, bits 7, 6, 3, 1 and 0 of the register are 0, the watchdog write-once lock is released, sys_src_pll, bus_clk_en, pll_pwrdn, rti_hold and cop_hold are 0, and osc_en is 1.
- R2: A write with bit 7 = 1 while pll_lock = 0 leaves bit 7 unchanged. A write with bit 7 = 1 while pll_lock = 1 sets it, and a write with bit 7 = 0 clears it.
- R3: Bit 7 clears at the edge where a stop entry occurs, at the edge where a self-clock entry occurs, and at the edge where a wait entry occurs while bit 3 = 1. If a write of 1 to bit 7 happens in the same cycle as one of these entries, the clear wins.
- R4: sys_src_pll follows bit 7 one cycle later. bus_clk_en inverts on every cycle. In the first cycle in which sys_src_pll shows a new value, bus_clk_en is 0.
- R5: pll_pwrdn is 1 in the cycle after each cycle that has wait_req = 1 and bit 3 = 1, and 0 otherwise. Bit 7 stays 0 after wait exits until software writes it again.
- R6: rti_hold is 1 in the cycle after each cycle that has wait_req = 1 and bit 1 = 1, and 0 otherwise.
- R7: cop_hold is 1 in the cycle after each cycle that has wait_req = 1 and bit 0 = 1. Bit 0 takes the first write after reset in normal mode (special_mode = 0) and ignores later normal-mode writes. In special mode it takes every write.
- R8: osc_en is 0 in the cycle after each cycle that has stop_req = 1 and bit 6 = 0, and 1 otherwise.
- R9: The readback has pll-select at bit 7, pseudo-stop at bit 6, the osc_cfg input at bit 5, pll-off-in-wait at bit 3, timer-off-in-wait at bit 1 and watchdog-off-in-wait at bit 0. Bits 4 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register readback |
| special_mode | input | 1 | 1 = special mode, in which the watchdog bit stays writable |
| pll_lock | input | 1 | PLL lock flag |
| osc_cfg | input | 1 | Oscillator config status: 0 loop-controlled, 1 external/full swing |
| wait_req | input | 1 | Wait mode request (level) |
| stop_req | input | 1 | Stop mode request (level) |
| selfclk_req | input | 1 | Self-clock mode request (level) |
| sys_src_pll | output | 1 | 1 = system clock taken from PLL |
| bus_clk_en | output | 1 | Divide-by-two bus clock enable |
| pll_pwrdn | output | 1 | PLL power-down request |
| osc_en | output | 1 | Oscillator enable |
| rti_hold | output | 1 | Periodic timer divider hold/clear |
| cop_hold | output | 1 | Watchdog counter hold/clear |

## Verification
The bench writes every 8-bit value both locked and unlocked. A design that let an unlocked write through would hand an unstable PLL clock to the system, and a design that dropped a bit would read back the wrong layout. It then walks all sixteen settings of the low-power bits through wait, stop and self-clock entries, including a PLL-select write in the very cycle of an entry. A design that lets the write win over the clear, or keeps the PLL selected across wait, shows up there. A final phase writes the watchdog bit repeatedly in normal mode and checks that reset re-opens it. A design that restarts the divider phase late, or not at all, puts a 1 on bus_clk_en in the first cycle of a new source.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_PLLSEL = 7;
  localparam int BIT_PSTP   = 6;
  localparam int BIT_OSCST  = 5;
  localparam int BIT_PLLOFF = 3;
  localparam int BIT_TMROFF = 1;
  localparam int BIT_WDGOFF = 0;
  localparam int N_MODES    = 3;
  localparam int M_WAIT     = 0;
  localparam int M_STOP     = 1;
  localparam int M_SELF     = 2;

  typedef struct packed {
    logic pll_sel;
    logic pseudo_stop;
    logic pll_off_wait;
    logic tmr_off_wait;
    logic wdg_off_wait;
  } ctl_t;
endpackage

// File: rtl/csc_mode_track.sv
module csc_mode_track #(
  parameter int NMODES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NMODES-1:0] req,
  output logic [NMODES-1:0] entry
);
  logic [NMODES-1:0] prev_q;

  for (genvar i = 0; i < NMODES; i++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= req[i];
    end

    assign entry[i] = req[i] & ~prev_q[i];

    // an entry pulse lasts one cycle (R3)
    p_entry_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      entry[i] |=> !entry[i]);
  end
endmodule

// File: rtl/csc_ctl_reg.sv
module csc_ctl_reg
  import clk_sel_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         special_mode,
  input  logic         pll_lock,
  input  logic         osc_cfg,
  input  logic         wait_entry,
  input  logic         stop_entry,
  input  logic         self_entry,
  output ctl_t         ctl,
  output logic [W-1:0] rd_data
);
  logic pll_q, pstp_q, plloff_q, tmroff_q, wdgoff_q, wdg_lock_q;
  logic pll_clr, pll_nxt;

  assign pll_clr = stop_entry | self_entry | (wait_entry & plloff_q);

  always_comb begin
    pll_nxt = pll_q;
    if (wr_en) begin
      if (!wr_data[BIT_PLLSEL]) pll_nxt = 1'b0;
      else if (pll_lock)        pll_nxt = 1'b1;
    end
    if (pll_clr) pll_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_q      <= 1'b0;
      pstp_q     <= 1'b0;
      plloff_q   <= 1'b0;
      tmroff_q   <= 1'b0;
      wdgoff_q   <= 1'b0;
      wdg_lock_q <= 1'b0;
    end else begin
      pll_q <= pll_nxt;
      if (wr_en) begin
        pstp_q   <= wr_data[BIT_PSTP];
        plloff_q <= wr_data[BIT_PLLOFF];
        tmroff_q <= wr_data[BIT_TMROFF];
        if (special_mode || !wdg_lock_q) wdgoff_q <= wr_data[BIT_WDGOFF];
        if (!special_mode) wdg_lock_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data             = '0;
    rd_data[BIT_PLLSEL] = pll_q;
    rd_data[BIT_PSTP]   = pstp_q;
    rd_data[BIT_OSCST]  = osc_cfg;
    rd_data[BIT_PLLOFF] = plloff_q;
    rd_data[BIT_TMROFF] = tmroff_q;
    rd_data[BIT_WDGOFF] = wdgoff_q;
  end

  assign ctl = '{pll_sel: pll_q, pseudo_stop: pstp_q, pll_off_wait: plloff_q,
                 tmr_off_wait: tmroff_q, wdg_off_wait: wdgoff_q};

  p_lock_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_q) |-> $past(pll_lock));
  p_entry_clear_r3: assert property (@(posedge clk) disable iff (rst)
    pll_clr |=> !pll_q);
  p_wdg_once_r7: assert property (@(posedge clk) disable iff (rst)
    (wdg_lock_q && !special_mode && wr_en) |=> $stable(wdgoff_q));
endmodule

// File: rtl/csc_bus_div.sv
module csc_bus_div (
  input  logic clk,
  input  logic rst,
  input  logic pll_sel,
  output logic sys_src_pll,
  output logic bus_clk_en
);
  logic src_q, en_q, switching;

  assign switching = (src_q != pll_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      src_q <= pll_sel;
      en_q  <= switching ? 1'b0 : ~en_q;
    end
  end

  assign sys_src_pll = src_q;
  assign bus_clk_en  = en_q;

  p_div_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    !switching |=> (bus_clk_en != $past(bus_clk_en)));
  p_div_restart_r4: assert property (@(posedge clk) disable iff (rst)
    switching |=> !bus_clk_en);
endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
  import clk_sel_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         special_mode,
  input  logic         pll_lock,
  input  logic         osc_cfg,
  input  logic         wait_req,
  input  logic         stop_req,
  input  logic         selfclk_req,
  output logic         sys_src_pll,
  output logic         bus_clk_en,
  output logic         pll_pwrdn,
  output logic         osc_en,
  output logic         rti_hold,
  output logic         cop_hold
);
  logic [N_MODES-1:0] req, entry;
  ctl_t ctl;
  logic pwrdn_q, osc_q, rti_q, cop_q;

  always_comb begin
    req         = '0;
    req[M_WAIT] = wait_req;
    req[M_STOP] = stop_req;
    req[M_SELF] = selfclk_req;
  end

  csc_mode_track #(.NMODES(N_MODES)) u_mode (
    .clk(clk), .rst(rst), .req(req), .entry(entry));

  csc_ctl_reg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .special_mode(special_mode), .pll_lock(pll_lock), .osc_cfg(osc_cfg),
    .wait_entry(entry[M_WAIT]), .stop_entry(entry[M_STOP]),
    .self_entry(entry[M_SELF]), .ctl(ctl), .rd_data(rd_data));

  csc_bus_div u_div (
    .clk(clk), .rst(rst), .pll_sel(ctl.pll_sel),
    .sys_src_pll(sys_src_pll), .bus_clk_en(bus_clk_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      pwrdn_q <= 1'b0;
      osc_q   <= 1'b1;
      rti_q   <= 1'b0;
      cop_q   <= 1'b0;
    end else begin
      pwrdn_q <= wait_req & ctl.pll_off_wait;
      osc_q   <= ~(stop_req & ~ctl.pseudo_stop);
      rti_q   <= wait_req & ctl.tmr_off_wait;
      cop_q   <= wait_req & ctl.wdg_off_wait;
    end
  end

  assign pll_pwrdn = pwrdn_q;
  assign osc_en    = osc_q;
  assign rti_hold  = rti_q;
  assign cop_hold  = cop_q;

  p_pwrdn_r5: assert property (@(posedge clk) disable iff (rst)
    (wait_req && rd_data[BIT_PLLOFF]) |=> pll_pwrdn);
  p_osc_off_r8: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !rd_data[BIT_PSTP]) |=> !osc_en);
  p_rti_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wait_req |=> !rti_hold);
  p_cop_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wait_req |=> !cop_hold);
endmodule

// File: tb/sim_clk_sel_ctrl.sv
module sim_clk_sel_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, special_mode = 1, pll_lock = 0, osc_cfg = 0;
  logic wait_req = 0, stop_req = 0, selfclk_req = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic sys_src_pll, bus_clk_en, pll_pwrdn, osc_en, rti_hold, cop_hold;
  int n_cmp = 0, n_bad = 0;

  // model state
  bit m_pll, m_pstp, m_plloff, m_tmr, m_wdg, m_lock;
  bit m_src, m_bus, m_pwr, m_osc, m_rti, m_cop, pw, ps, pc;

  always #10 clk = ~clk;

  clk_sel_ctrl u0 (.*);

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return {m_pll, m_pstp, osc_cfg, 1'b0, m_plloff, 1'b0, m_tmr, m_wdg};
  endfunction

  task automatic check_all();
    chk("R2 R3 R7 R9", "rd_data", rd_data, exp_rd());
    chk("R4", "sys_src_pll", {7'd0, sys_src_pll}, {7'd0, m_src});
    chk("R4", "bus_clk_en", {7'd0, bus_clk_en}, {7'd0, m_bus});
    chk("R5", "pll_pwrdn", {7'd0, pll_pwrdn}, {7'd0, m_pwr});
    chk("R8", "osc_en", {7'd0, osc_en}, {7'd0, m_osc});
    chk("R6", "rti_hold", {7'd0, rti_hold}, {7'd0, m_rti});
    chk("R7", "cop_hold", {7'd0, cop_hold}, {7'd0, m_cop});
  endtask

  task automatic model_reset();
    {m_pll, m_pstp, m_plloff, m_tmr, m_wdg, m_lock} = '0;
    {m_src, m_bus, m_pwr, m_rti, m_cop, pw, ps, pc} = '0;
    m_osc = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; wait_req = 0; stop_req = 0; selfclk_req = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: reset state
    chk("R1", "rd_data", rd_data, {2'b00, osc_cfg, 5'b0});
    chk("R1", "osc_en", {7'd0, osc_en}, 8'd1);
    chk("R1", "outs", {3'd0, sys_src_pll, bus_clk_en, pll_pwrdn, rti_hold, cop_hold}, 8'd0);
  endtask

  task automatic step(bit wr, logic [7:0] d, bit lk, bit sp, bit w, bit s, bit sc);
    bit ew, es, ec, nb;
    wr_en = wr; wr_data = d; pll_lock = lk; special_mode = sp;
    wait_req = w; stop_req = s; selfclk_req = sc;
    @(posedge clk);
    ew = w & ~pw; es = s & ~ps; ec = sc & ~pc;
    m_pwr = w & m_plloff; m_osc = ~(s & ~m_pstp);
    m_rti = w & m_tmr;    m_cop = w & m_wdg;
    nb = (m_pll != m_src) ? 1'b0 : ~m_bus;
    m_bus = nb; m_src = m_pll;
    if (ew & m_plloff | es | ec) m_pll = 1'b0;
    else if (wr) begin
      if (!d[7]) m_pll = 1'b0;
      else if (lk) m_pll = 1'b1;
    end
    if (wr) begin
      m_pstp = d[6]; m_plloff = d[3]; m_tmr = d[1];
      if (sp || !m_lock) m_wdg = d[0];
      if (!sp) m_lock = 1'b1;
    end
    pw = w; ps = s; pc = sc;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2 R9: every value, unlocked then locked, special mode
    for (int lk = 0; lk < 2; lk++)
      for (int v = 0; v < 256; v++) begin
        step(1, 8'(v), lk[0], 1, 0, 0, 0);
        step(0, 8'h00, lk[0], 1, 0, 0, 0);
      end
    osc_cfg = 1'b1;
    step(1, 8'h80, 1, 1, 0, 0, 0);
    step(1, 8'h00, 0, 1, 0, 0, 0); // R2 clear works unlocked
    // R3 R5 R6 R7 R8: low-power bit sweep through each mode
    for (int c = 0; c < 16; c++) begin
      logic [7:0] v;
      v = {1'b1, c[3], 2'b00, c[2], 1'b0, c[1], c[0]};
      step(1, v, 1, 1, 0, 0, 0);
      for (int k = 0; k < 3; k++) step(0, 0, 1, 1, 0, 0, 0);
      for (int k = 0; k < 3; k++) step(0, 0, 1, 1, 1, 0, 0);
      for (int k = 0; k < 2; k++) step(0, 0, 1, 1, 0, 0, 0);
      step(1, v, 1, 1, 0, 0, 0);
      for (int k = 0; k < 3; k++) step(0, 0, 1, 1, 0, 1, 0);
      step(0, 0, 1, 1, 0, 0, 0);
      step(1, v, 1, 1, 0, 0, 0);
      for (int k = 0; k < 2; k++) step(0, 0, 1, 1, 0, 0, 1);
      step(0, 0, 1, 1, 0, 0, 0);
      // R3: write of 1 in the entry cycle loses
      step(1, v, 1, 1, 0, 1, 0);
      step(1, v, 1, 1, 0, 0, 0);
      step(1, v, 1, 1, 1, 0, 0);
      step(1, v, 1, 1, 0, 0, 1);
      step(0, 0, 1, 1, 0, 0, 0);
    end
    // R7: write-once in normal mode, released by reset
    do_reset();
    step(1, 8'h01, 1, 0, 0, 0, 0);
    step(1, 8'h00, 1, 0, 0, 0, 0);
    step(1, 8'h8A, 1, 0, 1, 0, 0);
    step(0, 8'h00, 1, 0, 1, 0, 0);
    step(1, 8'h01, 1, 1, 0, 0, 0);
    step(1, 8'h00, 1, 1, 0, 0, 0);
    do_reset();
    step(1, 8'h00, 1, 0, 0, 0, 0);
    step(1, 8'h01, 1, 0, 0, 0, 0);
    step(0, 8'h00, 1, 0, 1, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule